// File: doc/BRIEF.md
# Parallel Port Register Interface

This block gives a host three byte-wide general-purpose ports, named A, B and C, behind a small register file. For every port the host programs a per-bit direction byte and an output latch. Pin outputs carry the latch, and each pin's output enable follows its direction bit. Pin inputs are brought into the clock domain through a two-stage synchronizer.

A data read returns a per-bit blend. Bits set as outputs return the latch, and bits set as inputs return the synchronized pin. Ports A and B each have a second read address that returns the same blend. Only the plain bit-I/O mode is implemented. A control write that selects any other general mode or port submode sets a sticky flag, and the written value is still stored.

The host bus is a single-cycle write strobe plus a read strobe. Read data is registered. The 5-bit register offset is taken from the low bits of a wider address input. An asynchronous active-low reset is released to the logic through a two-flop synchronizer.

Top module: `pario_regs`

## Requirements
- R1: While reset is active and after it, every register reads 0 except the port vector register at offset 5, which reads 0x0F. All pin enables, pin outputs, the read data and the unsupported-mode flag are 0.
- R2: Only the low 5 bits of `bus_addr` select a register. The upper bits have no effect on writes or reads.
- R3: `pin_x_oe` equals the direction byte of port x and `pin_x_out` equals its latch. Both change at the clock edge that samples a write to that port's direction or data offset (A: 2/8, B: 3/9, C: 4/12).
- R4: A read of offset 8 (A) or 9 (B) returns, per bit, the latch where the direction bit is 1 and the synchronized pin where it is 0.
- R5: Port C uses the same blend, built from its direction at offset 4 and its latch at offset 12.
- R6: Offsets 10 and 11 read back the same blended value as offsets 8 and 9. Writes to offsets 10 and 11 change nothing.
- R7: A pin value must be stable for two clock edges before it shows in the blend. A read sampled at the third edge after the pin changes returns the new value, and reads at the first and second edges return the old one.
- R8: A write of offset 0 with bits 7:6 not equal to 00, or of offset 6 or 7 with bits 7:6 not equal to 01, sets `mode_err`. The flag stays set until reset, and the written byte is stored and reads back.
- R9: `bus_rdata` is loaded at the clock edge where `bus_re` is high and holds at all other edges. A read and a write to the same offset in the same cycle return the value from before the write.
- R10: Offsets 0, 1, 5, 6, 7 and 13 are plain read/write bytes. Offsets 14 to 31 read as 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | BUS_AW (8) | Register address; low 5 bits decoded |
| bus_wdata | input | DW (8) | Write data |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DW (8) | Registered read data |
| pin_a_in | input | DW (8) | Port A pin inputs, asynchronous |
| pin_a_out | output | DW (8) | Port A pin output values |
| pin_a_oe | output | DW (8) | Port A per-bit output enables |
| pin_b_in | input | DW (8) | Port B pin inputs, asynchronous |
| pin_b_out | output | DW (8) | Port B pin output values |
| pin_b_oe | output | DW (8) | Port B per-bit output enables |
| pin_c_in | input | DW (8) | Port C pin inputs, asynchronous |
| pin_c_out | output | DW (8) | Port C pin output values |
| pin_c_oe | output | DW (8) | Port C per-bit output enables |
| mode_err | output | 1 | Sticky unsupported-mode flag |

## Verification
Writes show on the pin outputs, enables and `mode_err` one edge after the strobe. A read result shows on `bus_rdata` after the edge that samples `bus_re`. A pin change reaches that result only at the third edge after the change. The bench drives every input on the falling edge and samples all outputs on the next falling edge. A behavioural model updated at each rising edge is compared with all outputs on every cycle. The directed read checks for the synchronizer latency sample the first, second and third falling edges after the pin change, so each stage of the delay is pinned down.

// File: rtl/pario_pkg.sv
`timescale 1ns/1ps
package pario_pkg;
  localparam int REG_AW = 5;
  localparam int NPORT  = 3;
  typedef logic [REG_AW-1:0] raddr_t;

  localparam raddr_t OFS_GCTL  = 5'd0;
  localparam raddr_t OFS_SREQ  = 5'd1;
  localparam raddr_t OFS_DIRA  = 5'd2;
  localparam raddr_t OFS_DIRB  = 5'd3;
  localparam raddr_t OFS_DIRC  = 5'd4;
  localparam raddr_t OFS_PVEC  = 5'd5;
  localparam raddr_t OFS_CTLA  = 5'd6;
  localparam raddr_t OFS_CTLB  = 5'd7;
  localparam raddr_t OFS_DATA  = 5'd8;
  localparam raddr_t OFS_DATB  = 5'd9;
  localparam raddr_t OFS_ALTA  = 5'd10;
  localparam raddr_t OFS_ALTB  = 5'd11;
  localparam raddr_t OFS_DATC  = 5'd12;
  localparam raddr_t OFS_PSTAT = 5'd13;

  localparam logic [7:0] PVEC_RESET = 8'h0F;
  localparam logic [1:0] GMODE_OK   = 2'b00;
  localparam logic [1:0] SUBMODE_OK = 2'b01;

  function automatic raddr_t dir_ofs(int p);
    return (p == 0) ? OFS_DIRA : (p == 1) ? OFS_DIRB : OFS_DIRC;
  endfunction

  function automatic raddr_t dat_ofs(int p);
    return (p == 0) ? OFS_DATA : (p == 1) ? OFS_DATB : OFS_DATC;
  endfunction
endpackage

// File: rtl/pario_rst_sync.sv
`timescale 1ns/1ps
module pario_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/pario_sync.sv
`timescale 1ns/1ps
module pario_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q, hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= async_in;
      hold_q <= meta_q;
    end
  end

  assign sync_out = hold_q;
endmodule

// File: rtl/pario_port.sv
`timescale 1ns/1ps
module pario_port #(
  parameter int                DW       = 8,
  parameter int                AW       = 5,
  parameter logic [AW-1:0]     DIR_OFS  = '0,
  parameter logic [AW-1:0]     DAT_OFS  = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_ofs,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] pin_in,
  output logic [DW-1:0] dir_q,
  output logic [DW-1:0] lat_q,
  output logic [DW-1:0] rd_blend
);
  logic [DW-1:0] dir_d, lat_d, pin_s;
  logic          dir_we, lat_we;

  pario_sync #(.W(DW)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (pin_s)
  );

  assign dir_we = wr_en && (wr_ofs == DIR_OFS);
  assign lat_we = wr_en && (wr_ofs == DAT_OFS);

  always_comb begin
    dir_d = dir_q;
    lat_d = lat_q;
    if (dir_we) dir_d = wr_data;
    if (lat_we) lat_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      lat_q <= '0;
    end else begin
      dir_q <= dir_d;
      lat_q <= lat_d;
    end
  end

  assign rd_blend = (lat_q & dir_q) | (pin_s & ~dir_q);
endmodule

// File: rtl/pario_regs.sv
`timescale 1ns/1ps
module pario_regs
  import pario_pkg::*;
#(
  parameter int BUS_AW = 8,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DW-1:0]     bus_rdata,
  input  logic [DW-1:0]     pin_a_in,
  output logic [DW-1:0]     pin_a_out,
  output logic [DW-1:0]     pin_a_oe,
  input  logic [DW-1:0]     pin_b_in,
  output logic [DW-1:0]     pin_b_out,
  output logic [DW-1:0]     pin_b_oe,
  input  logic [DW-1:0]     pin_c_in,
  output logic [DW-1:0]     pin_c_out,
  output logic [DW-1:0]     pin_c_oe,
  output logic              mode_err
);
  localparam int MSB = DW - 1;

  logic          rst_sync_n;
  raddr_t        ofs;
  logic          unused_addr_hi;
  logic [MSB:0]  pin_in_v [NPORT];
  logic [MSB:0]  dir_v    [NPORT];
  logic [MSB:0]  lat_v    [NPORT];
  logic [MSB:0]  blend_v  [NPORT];

  logic [MSB:0]  gctl_q, sreq_q, pvec_q, ctla_q, ctlb_q, pstat_q;
  logic [MSB:0]  gctl_d, sreq_d, pvec_d, ctla_d, ctlb_d, pstat_d;
  logic          err_q, err_d, bad_mode;
  logic [MSB:0]  rd_mux, rdata_q, rdata_d;

  pario_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign ofs            = bus_addr[REG_AW-1:0];
  assign unused_addr_hi = ^bus_addr[BUS_AW-1:REG_AW];

  assign pin_in_v[0] = pin_a_in;
  assign pin_in_v[1] = pin_b_in;
  assign pin_in_v[2] = pin_c_in;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    pario_port #(
      .DW      (DW),
      .AW      (REG_AW),
      .DIR_OFS (dir_ofs(p)),
      .DAT_OFS (dat_ofs(p))
    ) u_port (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .wr_en    (bus_we),
      .wr_ofs   (ofs),
      .wr_data  (bus_wdata),
      .pin_in   (pin_in_v[p]),
      .dir_q    (dir_v[p]),
      .lat_q    (lat_v[p]),
      .rd_blend (blend_v[p])
    );
  end

  assign pin_a_oe  = dir_v[0];
  assign pin_b_oe  = dir_v[1];
  assign pin_c_oe  = dir_v[2];
  assign pin_a_out = lat_v[0];
  assign pin_b_out = lat_v[1];
  assign pin_c_out = lat_v[2];

  always_comb begin
    gctl_d  = gctl_q;
    sreq_d  = sreq_q;
    pvec_d  = pvec_q;
    ctla_d  = ctla_q;
    ctlb_d  = ctlb_q;
    pstat_d = pstat_q;
    bad_mode = 1'b0;
    if (bus_we) begin
      unique case (ofs)
        OFS_GCTL: begin
          gctl_d   = bus_wdata;
          bad_mode = (bus_wdata[MSB -: 2] != GMODE_OK);
        end
        OFS_SREQ:  sreq_d  = bus_wdata;
        OFS_PVEC:  pvec_d  = bus_wdata;
        OFS_CTLA: begin
          ctla_d   = bus_wdata;
          bad_mode = (bus_wdata[MSB -: 2] != SUBMODE_OK);
        end
        OFS_CTLB: begin
          ctlb_d   = bus_wdata;
          bad_mode = (bus_wdata[MSB -: 2] != SUBMODE_OK);
        end
        OFS_PSTAT: pstat_d = bus_wdata;
        default: ;
      endcase
    end
    err_d = err_q | bad_mode;
  end

  always_comb begin
    case (ofs)
      OFS_GCTL:            rd_mux = gctl_q;
      OFS_SREQ:            rd_mux = sreq_q;
      OFS_DIRA:            rd_mux = dir_v[0];
      OFS_DIRB:            rd_mux = dir_v[1];
      OFS_DIRC:            rd_mux = dir_v[2];
      OFS_PVEC:            rd_mux = pvec_q;
      OFS_CTLA:            rd_mux = ctla_q;
      OFS_CTLB:            rd_mux = ctlb_q;
      OFS_DATA, OFS_ALTA:  rd_mux = blend_v[0];
      OFS_DATB, OFS_ALTB:  rd_mux = blend_v[1];
      OFS_DATC:            rd_mux = blend_v[2];
      OFS_PSTAT:           rd_mux = pstat_q;
      default:             rd_mux = '0;
    endcase
    rdata_d = bus_re ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      gctl_q  <= '0;
      sreq_q  <= '0;
      pvec_q  <= DW'(PVEC_RESET);
      ctla_q  <= '0;
      ctlb_q  <= '0;
      pstat_q <= '0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      gctl_q  <= gctl_d;
      sreq_q  <= sreq_d;
      pvec_q  <= pvec_d;
      ctla_q  <= ctla_d;
      ctlb_q  <= ctlb_d;
      pstat_q <= pstat_d;
      err_q   <= err_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign mode_err  = err_q;
endmodule

// File: rtl/pario_chk.sv
`timescale 1ns/1ps
module pario_chk #(
  parameter int BUS_AW = 8,
  parameter int DW     = 8
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic              bus_we,
  input logic              bus_re,
  input logic [DW-1:0]     bus_rdata,
  input logic [DW-1:0]     pin_a_out,
  input logic [DW-1:0]     pin_a_oe,
  input logic              mode_err
);
  logic [4:0] lo;
  assign lo = bus_addr[4:0];

  a_r3_oe_follows_dir: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_we && lo == 5'd2) |=> (pin_a_oe == $past(bus_wdata)));

  a_r3_oe_holds: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(bus_we && lo == 5'd2) |=> $stable(pin_a_oe));

  a_r2_latch_low_bits: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_we && lo == 5'd8) |=> (pin_a_out == $past(bus_wdata)));

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mode_err |=> mode_err);

  a_r8_bad_general_mode: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_we && lo == 5'd0 && bus_wdata[DW-1 -: 2] != 2'b00) |=> mode_err);

  a_r9_rdata_holds: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bus_re |=> $stable(bus_rdata));

  a_r10_unused_reads_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_re && lo >= 5'd14) |=> (bus_rdata == '0));
endmodule

bind pario_regs pario_chk #(.BUS_AW(BUS_AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_we     (bus_we),
  .bus_re     (bus_re),
  .bus_rdata  (bus_rdata),
  .pin_a_out  (pin_a_out),
  .pin_a_oe   (pin_a_oe),
  .mode_err   (mode_err)
);

// File: tb/sim_pario_regs.sv
`timescale 1ns/1ps
module sim_pario_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic       bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_a_in = 8'h3C, pin_b_in = 8'h81, pin_c_in = 8'h5A;
  logic [7:0] pin_a_out, pin_a_oe, pin_b_out, pin_b_oe, pin_c_out, pin_c_oe;
  logic       mode_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit cmp_en  = 1'b0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  pario_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .pin_a_in(pin_a_in), .pin_a_out(pin_a_out), .pin_a_oe(pin_a_oe),
    .pin_b_in(pin_b_in), .pin_b_out(pin_b_out), .pin_b_oe(pin_b_oe),
    .pin_c_in(pin_c_in), .pin_c_out(pin_c_out), .pin_c_oe(pin_c_oe),
    .mode_err(mode_err)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_reg [0:31];
  logic [7:0] m_s1 [0:2];
  logic [7:0] m_s2 [0:2];
  logic [7:0] m_rd;
  logic       m_err, m_r1, m_r2;

  function automatic logic [7:0] m_blend(int p);
    int d;
    d = (p == 2) ? 12 : 8 + p;
    return (m_reg[d] & m_reg[2 + p]) | (m_s2[p] & ~m_reg[2 + p]);
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 32; i++) m_reg[i] = 8'h00;
    m_reg[5] = 8'h0F;
    for (int p = 0; p < 3; p++) begin m_s1[p] = '0; m_s2[p] = '0; end
    m_rd = '0;
    m_err = 1'b0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reset();
      m_r1 = 1'b0;
      m_r2 = 1'b0;
    end else begin
      if (!m_r2) m_reset();
      else begin
        int a;
        logic [7:0] nrd;
        a = int'(bus_addr[4:0]);
        nrd = m_rd;
        if (bus_re) begin
          if (a == 8 || a == 10)       nrd = m_blend(0);
          else if (a == 9 || a == 11)  nrd = m_blend(1);
          else if (a == 12)            nrd = m_blend(2);
          else if (a <= 13)            nrd = m_reg[a];
          else                         nrd = 8'h00;
        end
        if (bus_we) begin
          if (a <= 9 || a == 12 || a == 13) m_reg[a] = bus_wdata;
          if (a == 0 && bus_wdata[7:6] != 2'b00) m_err = 1'b1;
          if ((a == 6 || a == 7) && bus_wdata[7:6] != 2'b01) m_err = 1'b1;
        end
        m_rd = nrd;
        for (int p = 0; p < 3; p++) m_s2[p] = m_s1[p];
        m_s1[0] = pin_a_in;
        m_s1[1] = pin_b_in;
        m_s1[2] = pin_c_in;
      end
      m_r2 = m_r1;
      m_r1 = 1'b1;
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk("R3 model pin_a_oe",  pin_a_oe,  m_reg[2]);
      chk("R3 model pin_b_oe",  pin_b_oe,  m_reg[3]);
      chk("R5 model pin_c_oe",  pin_c_oe,  m_reg[4]);
      chk("R3 model pin_a_out", pin_a_out, m_reg[8]);
      chk("R3 model pin_b_out", pin_b_out, m_reg[9]);
      chk("R5 model pin_c_out", pin_c_out, m_reg[12]);
      chk("R9 model bus_rdata", bus_rdata, m_rd);
      chk("R8 model mode_err",  {7'b0, mode_err}, {7'b0, m_err});
    end
  end

  // ---------------- bus tasks ----------------
  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [7:0] exp, string req);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    chk(req, bus_rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    cmp_en = 1'b1;
    @(negedge clk); #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    chk("R1 pin_a_oe", pin_a_oe, 8'h00);
    chk("R1 mode_err", {7'b0, mode_err}, 8'h00);
    rd(8'd5, 8'h0F, "R1 vector reset");
    rd(8'd0, 8'h00, "R1 general control reset");

    // R3/R4/R6 port A
    wr(8'd2, 8'hF0);
    wr(8'd8, 8'hA5);
    chk("R3 pin_a_oe", pin_a_oe, 8'hF0);
    chk("R3 pin_a_out", pin_a_out, 8'hA5);
    rd(8'd8, 8'hAC, "R4 port A blend");
    rd(8'd10, 8'hAC, "R6 port A alternate");

    // R2 upper address bits ignored
    wr(8'hE8, 8'h11);
    chk("R2 upper bits write", pin_a_out, 8'h11);
    rd(8'h68, 8'h1C, "R2 upper bits read");

    // R5 port C
    wr(8'd4, 8'h0F);
    wr(8'd12, 8'h96);
    chk("R5 pin_c_oe", pin_c_oe, 8'h0F);
    rd(8'd12, 8'h56, "R5 port C blend");

    // R6 port B, alternate write ignored
    wr(8'd3, 8'hFF);
    wr(8'd9, 8'h33);
    wr(8'd11, 8'hCC);
    chk("R6 pin_b_out after alt write", pin_b_out, 8'h33);
    rd(8'd11, 8'h33, "R6 port B alternate");
    rd(8'd9, 8'h33, "R6 port B data");

    // R10 unused and plain registers
    wr(8'd20, 8'h77);
    rd(8'd20, 8'h00, "R10 unused offset");
    wr(8'd13, 8'h5E);
    rd(8'd13, 8'h5E, "R10 plain register");

    // R8 mode flag
    wr(8'd6, 8'h41);
    chk("R8 good submode", {7'b0, mode_err}, 8'h00);
    rd(8'd6, 8'h41, "R8 control readback");
    wr(8'd0, 8'h3F);
    chk("R8 good general mode", {7'b0, mode_err}, 8'h00);
    wr(8'd7, 8'hC0);
    chk("R8 bad submode sets", {7'b0, mode_err}, 8'h01);
    rd(8'd7, 8'hC0, "R8 bad value stored");
    wr(8'd7, 8'h40);
    chk("R8 sticky", {7'b0, mode_err}, 8'h01);

    // R9 simultaneous read and write, then hold
    @(negedge clk);
    bus_we = 1'b1; bus_re = 1'b1; bus_addr = 8'd13; bus_wdata = 8'h99;
    @(negedge clk);
    bus_we = 1'b0; bus_re = 1'b0;
    chk("R9 read before write", bus_rdata, 8'h5E);
    repeat (3) @(negedge clk);
    chk("R9 rdata holds", bus_rdata, 8'h5E);
    rd(8'd13, 8'h99, "R9 written value");

    // R7 synchronizer latency
    wr(8'd2, 8'h00);
    repeat (3) @(negedge clk);
    pin_a_in = 8'h12; bus_re = 1'b1; bus_addr = 8'd8;
    @(negedge clk);
    chk("R7 first edge old", bus_rdata, 8'h3C);
    @(negedge clk);
    chk("R7 second edge old", bus_rdata, 8'h3C);
    @(negedge clk);
    chk("R7 third edge new", bus_rdata, 8'h12);
    bus_re = 1'b0;

    // R1 reset again mid-run
    @(negedge clk); #1 rst_n = 1'b0;
    @(negedge clk);
    chk("R1 oe cleared by reset", pin_b_oe, 8'h00);
    chk("R1 flag cleared by reset", {7'b0, mode_err}, 8'h00);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(8'd7, 8'h00, "R1 control after reset");
    rd(8'd5, 8'h0F, "R1 vector after reset");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule